// File: doc/BRIEF.md
# Timer and External Interrupt Control Register

This block is an 8-bit special-function register for a small microcontroller core. It holds the run enables and overflow flags of two timers, and the mode bits and request flags of two active-low external interrupt pins. The timers see their run enables on dedicated outputs and report overflow through one-cycle strobes. The interrupt controller sees four request outputs and returns one acknowledge strobe per source when it vectors to that source.

Each external request bit works in one of two modes, picked by its mode bit. In edge mode the bit is a latched flag. A high-to-low transition of the pin sets it. A vector acknowledge or a software write clears it. In level mode the bit follows the inverted pin and ignores writes and acknowledges. The raw pins pass through a two-flop synchronizer. Edge detection compares the synchronized sample with the one taken a cycle before. The reset input is asynchronous active-low, and its release is synchronized inside the block.

Top module: `tmr_xint_ctrl`

## Requirements
- R1: After reset every register bit is 0, so the read value at address 0x88 is 0x00 and all request and run outputs are 0.
- R2: A write strobe with address 0x88 loads the register on the next clock edge. Bit layout, MSB first: timer1 flag (7), timer1 run (6), timer0 flag (5), timer0 run (4), int1 request (3), int1 mode (2), int0 request (1), int0 mode (0). Timer n's run output equals its run bit. Writes to any other address change nothing. Reads at any other address return 0x00.
- R3: An overflow strobe on timer n sets that timer's flag at the next clock edge. Each timer request output equals its flag bit.
- R4: An acknowledge strobe for timer n clears that timer's flag at the next clock edge.
- R5: When a timer overflow strobe arrives in the same cycle as a software write or an acknowledge, the flag ends up set.
- R6: Software can set or clear a timer flag by writing the register.
- R7: With mode bit 1 (edge), a high-to-low pin transition sets the request bit on the third clock edge after the pin falls. A pin held low or a rising pin sets nothing further.
- R8: In edge mode, an acknowledge for that interrupt clears the request bit, and a software write loads it with the written value.
- R9: With mode bit 0 (level), the request bit reads 1 while the pin is low and 0 while it is high, three clock edges behind the pin.
- R10: In level mode, software writes and acknowledges leave the request bit unchanged.
- R11: When a detected falling edge coincides with an acknowledge or a software write of 0, the request bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Register address for read and write |
| sfr_wr | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data, 0x00 unless the address is 0x88 |
| tmr_ovf | input | 2 | Overflow strobe per timer |
| ack_tmr | input | 2 | Vector acknowledge per timer interrupt |
| ack_xint | input | 2 | Vector acknowledge per external interrupt |
| xint_n | input | 2 | Raw active-low external interrupt pins |
| tmr_run | output | 2 | Run enable per timer |
| irq_tmr | output | 2 | Timer interrupt requests |
| irq_xint | output | 2 | External interrupt requests |

## Verification
The hardest case to reach is the collision between a detected pin edge and an acknowledge or write of the same request bit. The edge becomes visible only after two synchronizer stages, so the acknowledge has to land exactly in the cycle when the edge term is active. The stimulus drives the pin low on a falling clock edge, waits two clock cycles, and then drives the acknowledge and a clearing write for one cycle. It then checks that the flag is set. Level mode is exercised separately: writes and acknowledges are driven while the pin is held low and again while it is high.

// File: rtl/tmr_xint_pkg.sv
package tmr_xint_pkg;
  localparam int unsigned SFR_AW   = 8;
  localparam int unsigned SRC_N    = 2;
  localparam int unsigned REG_W    = 4 * SRC_N;
  localparam logic [SFR_AW-1:0] CTRL_ADDR = 8'h88;

  // bit index helpers: timers in the upper half, pins in the lower half
  function automatic int unsigned tflag_idx(input int unsigned n);
    return REG_W / 2 + 2 * n + 1;
  endfunction
  function automatic int unsigned trun_idx(input int unsigned n);
    return REG_W / 2 + 2 * n;
  endfunction
  function automatic int unsigned xreq_idx(input int unsigned n);
    return 2 * n + 1;
  endfunction
  function automatic int unsigned xmode_idx(input int unsigned n);
    return 2 * n;
  endfunction
endpackage

// File: rtl/tx_sync2.sv
module tx_sync2 #(
  parameter int unsigned W       = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= {W{RST_VAL}};
      stg2_q <= {W{RST_VAL}};
    end else begin
      stg1_q <= d;
      stg2_q <= stg1_q;
    end
  end

  assign q = stg2_q;
endmodule

// File: rtl/tx_tmr_slot.sv
module tx_tmr_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wr_flag,
  input  logic wr_run,
  input  logic ovf,
  input  logic ack,
  output logic flag_q,
  output logic run_q
);
  logic flag_d, run_d;

  always_comb begin
    flag_d = flag_q;
    if (ovf)         flag_d = 1'b1;
    else if (wr_hit) flag_d = wr_flag;
    else if (ack)    flag_d = 1'b0;
  end

  always_comb begin
    run_d = run_q;
    if (wr_hit) run_d = wr_run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      run_q  <= run_d;
    end
  end
endmodule

// File: rtl/tx_xint_slot.sv
module tx_xint_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic wr_hit,
  input  logic wr_req,
  input  logic wr_mode,
  input  logic ack,
  output logic req_q,
  output logic mode_q
);
  logic prev_q;
  logic fall;
  logic req_d, mode_d;

  assign fall = prev_q & ~pin_s;

  always_comb begin
    req_d = req_q;
    if (!mode_q)     req_d = ~pin_s;
    else if (fall)   req_d = 1'b1;
    else if (wr_hit) req_d = wr_req;
    else if (ack)    req_d = 1'b0;
  end

  always_comb begin
    mode_d = mode_q;
    if (wr_hit) mode_d = wr_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      req_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      req_q  <= req_d;
      mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/tmr_xint_ctrl.sv
module tmr_xint_ctrl
  import tmr_xint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [REG_W-1:0]  sfr_wdata,
  output logic [REG_W-1:0]  sfr_rdata,
  input  logic [SRC_N-1:0]  tmr_ovf,
  input  logic [SRC_N-1:0]  ack_tmr,
  input  logic [SRC_N-1:0]  ack_xint,
  input  logic [SRC_N-1:0]  xint_n,
  output logic [SRC_N-1:0]  tmr_run,
  output logic [SRC_N-1:0]  irq_tmr,
  output logic [SRC_N-1:0]  irq_xint
);
  logic [1:0]       rst_pipe_q;
  logic             rst_ns;
  logic             sel;
  logic             wr_hit;
  logic [SRC_N-1:0] pin_s;
  logic [SRC_N-1:0] xint_mode;
  logic [REG_W-1:0] ctrl_reg;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ns = rst_pipe_q[1];

  assign sel    = (sfr_addr == CTRL_ADDR);
  assign wr_hit = sfr_wr & sel;

  tx_sync2 #(.W(SRC_N), .RST_VAL(1'b1)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_ns),
    .d     (xint_n),
    .q     (pin_s)
  );

  for (genvar n = 0; n < SRC_N; n++) begin : g_src
    tx_tmr_slot u_tmr (
      .clk     (clk),
      .rst_n   (rst_ns),
      .wr_hit  (wr_hit),
      .wr_flag (sfr_wdata[tflag_idx(n)]),
      .wr_run  (sfr_wdata[trun_idx(n)]),
      .ovf     (tmr_ovf[n]),
      .ack     (ack_tmr[n]),
      .flag_q  (irq_tmr[n]),
      .run_q   (tmr_run[n])
    );

    tx_xint_slot u_xint (
      .clk     (clk),
      .rst_n   (rst_ns),
      .pin_s   (pin_s[n]),
      .wr_hit  (wr_hit),
      .wr_req  (sfr_wdata[xreq_idx(n)]),
      .wr_mode (sfr_wdata[xmode_idx(n)]),
      .ack     (ack_xint[n]),
      .req_q   (irq_xint[n]),
      .mode_q  (xint_mode[n])
    );

    assign ctrl_reg[tflag_idx(n)] = irq_tmr[n];
    assign ctrl_reg[trun_idx(n)]  = tmr_run[n];
    assign ctrl_reg[xreq_idx(n)]  = irq_xint[n];
    assign ctrl_reg[xmode_idx(n)] = xint_mode[n];
  end

  assign sfr_rdata = sel ? ctrl_reg : '0;
endmodule

// File: rtl/tmr_xint_ctrl_chk.sv
module tmr_xint_ctrl_chk
  import tmr_xint_pkg::*;
(
  input logic              clk,
  input logic              rst_ns,
  input logic [SFR_AW-1:0] sfr_addr,
  input logic              sfr_wr,
  input logic [REG_W-1:0]  sfr_wdata,
  input logic [REG_W-1:0]  sfr_rdata,
  input logic [SRC_N-1:0]  tmr_ovf,
  input logic [SRC_N-1:0]  ack_tmr,
  input logic [SRC_N-1:0]  ack_xint,
  input logic [SRC_N-1:0]  xint_n,
  input logic [SRC_N-1:0]  tmr_run,
  input logic [SRC_N-1:0]  irq_tmr,
  input logic [SRC_N-1:0]  irq_xint,
  input logic [SRC_N-1:0]  xint_mode
);
  logic [2:0] cyc_q;
  logic       hit;
  logic       warm;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)           cyc_q <= 3'd0;
    else if (cyc_q != 3'd7) cyc_q <= cyc_q + 3'd1;
  end

  assign hit  = sfr_wr && (sfr_addr == CTRL_ADDR);
  assign warm = (cyc_q >= 3'd5);

  p_rd_other_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (sfr_addr != CTRL_ADDR) |-> (sfr_rdata == '0));

  for (genvar i = 0; i < SRC_N; i++) begin : g_chk
    p_run_wr_r2: assert property (@(posedge clk) disable iff (!rst_ns)
      hit |=> (tmr_run[i] == $past(sfr_wdata[trun_idx(i)])));

    p_mode_wr_r2: assert property (@(posedge clk) disable iff (!rst_ns)
      hit |=> (xint_mode[i] == $past(sfr_wdata[xmode_idx(i)])));

    p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_ns)
      tmr_ovf[i] |=> irq_tmr[i]);  // also covers R5

    p_ack_clr_r4: assert property (@(posedge clk) disable iff (!rst_ns)
      (ack_tmr[i] && !tmr_ovf[i] && !hit) |=> !irq_tmr[i]);

    p_tf_wr_r6: assert property (@(posedge clk) disable iff (!rst_ns)
      (hit && !tmr_ovf[i]) |=> (irq_tmr[i] == $past(sfr_wdata[tflag_idx(i)])));

    p_edge_set_r7: assert property (@(posedge clk) disable iff (!rst_ns)
      (warm && xint_mode[i] && $past(xint_n[i], 3) && !$past(xint_n[i], 2))
      |=> irq_xint[i]);  // also covers R11

    p_edge_wr_r8: assert property (@(posedge clk) disable iff (!rst_ns)
      (warm && hit && xint_mode[i] && !($past(xint_n[i], 3) && !$past(xint_n[i], 2)))
      |=> (irq_xint[i] == $past(sfr_wdata[xreq_idx(i)])));

    p_edge_ack_r8: assert property (@(posedge clk) disable iff (!rst_ns)
      (warm && ack_xint[i] && !hit && xint_mode[i] &&
       !($past(xint_n[i], 3) && !$past(xint_n[i], 2)))
      |=> !irq_xint[i]);

    p_lvl_mirror_r9: assert property (@(posedge clk) disable iff (!rst_ns)
      (warm && !xint_mode[i]) |=> (irq_xint[i] == !$past(xint_n[i], 3)));  // also R10
  end
endmodule

bind tmr_xint_ctrl tmr_xint_ctrl_chk u_chk (
  .clk       (clk),
  .rst_ns    (rst_ns),
  .sfr_addr  (sfr_addr),
  .sfr_wr    (sfr_wr),
  .sfr_wdata (sfr_wdata),
  .sfr_rdata (sfr_rdata),
  .tmr_ovf   (tmr_ovf),
  .ack_tmr   (ack_tmr),
  .ack_xint  (ack_xint),
  .xint_n    (xint_n),
  .tmr_run   (tmr_run),
  .irq_tmr   (irq_tmr),
  .irq_xint  (irq_xint),
  .xint_mode (xint_mode)
);

// File: tb/tmr_xint_ctrl_tb.sv
module tmr_xint_ctrl_tb;
  localparam time CLK_P = 10ns;
  localparam int  NV    = 14;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] sfr_addr;
  logic       sfr_wr;
  logic [7:0] sfr_wdata;
  logic [7:0] sfr_rdata;
  logic [1:0] tmr_ovf, ack_tmr, ack_xint, xint_n;
  logic [1:0] tmr_run, irq_tmr, irq_xint;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  tmr_xint_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .tmr_ovf(tmr_ovf),
    .ack_tmr(ack_tmr), .ack_xint(ack_xint), .xint_n(xint_n),
    .tmr_run(tmr_run), .irq_tmr(irq_tmr), .irq_xint(irq_xint)
  );

  // {wr, addr, wdata, ovf, ack_tmr, ack_xint, expected read}
  localparam logic [30:0] VECS [0:NV-1] = '{
    {1'b1, 8'h88, 8'h50, 2'b00, 2'b00, 2'b00, 8'h50},  // R2 run bits
    {1'b1, 8'h89, 8'hFF, 2'b00, 2'b00, 2'b00, 8'h50},  // R2 other address
    {1'b0, 8'h88, 8'h00, 2'b01, 2'b00, 2'b00, 8'h70},  // R3 timer0
    {1'b0, 8'h88, 8'h00, 2'b10, 2'b00, 2'b00, 8'hF0},  // R3 timer1
    {1'b0, 8'h88, 8'h00, 2'b00, 2'b01, 2'b00, 8'hD0},  // R4
    {1'b0, 8'h88, 8'h00, 2'b10, 2'b10, 2'b00, 8'hD0},  // R5 ovf vs ack
    {1'b1, 8'h88, 8'h50, 2'b01, 2'b00, 2'b00, 8'h70},  // R5 ovf vs write, R6
    {1'b1, 8'h88, 8'hA0, 2'b00, 2'b00, 2'b00, 8'hA0},  // R6 set flags
    {1'b1, 8'h88, 8'h0A, 2'b00, 2'b00, 2'b00, 8'h00},  // R10 level write
    {1'b1, 8'h88, 8'h05, 2'b00, 2'b00, 2'b00, 8'h05},  // R2 modes
    {1'b1, 8'h88, 8'h0F, 2'b00, 2'b00, 2'b00, 8'h0F},  // R8 write sets
    {1'b0, 8'h88, 8'h00, 2'b00, 2'b00, 2'b01, 8'h0D},  // R8 ack int0
    {1'b0, 8'h88, 8'h00, 2'b00, 2'b00, 2'b10, 8'h05},  // R8 ack int1
    {1'b1, 8'h88, 8'h00, 2'b00, 2'b00, 2'b00, 8'h00}   // R9 level, pins high
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    sfr_wr = 1'b0; sfr_addr = 8'h88; sfr_wdata = 8'h00;
    tmr_ovf = 2'b00; ack_tmr = 2'b00; ack_xint = 2'b00;
  endtask

  task automatic wr_reg(input logic [7:0] d);
    @(negedge clk);
    sfr_wr = 1'b1; sfr_addr = 8'h88; sfr_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 50000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    xint_n = 2'b11;
    idle();
    rst_n = 1'b0;
    do_reset();
    #1;
    check("R1 read after reset", sfr_rdata, 8'h00);
    check("R1 outputs after reset", {2'b00, tmr_run, irq_tmr, irq_xint}, 8'h00);

    // vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {sfr_wr, sfr_addr, sfr_wdata, tmr_ovf, ack_tmr, ack_xint} = VECS[v][30:8];
      @(negedge clk);
      idle();
      #1;
      check($sformatf("R2 vector %0d read", v), sfr_rdata, VECS[v][7:0]);
      check($sformatf("R3 vector %0d outputs", v),
            {2'b00, tmr_run, irq_tmr, irq_xint},
            {2'b00, VECS[v][6], VECS[v][4], VECS[v][7], VECS[v][5], VECS[v][3], VECS[v][1]});
    end

    // R2 read at another address returns zero
    sfr_addr = 8'h87; #1;
    check("R2 read other address", sfr_rdata, 8'h00);
    idle();

    // R7 edge mode on int0
    wr_reg(8'h05);
    xint_n[0] = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 no set before third edge", {7'b0, irq_xint[0]}, 8'h00);
    @(negedge clk);
    check("R7 set on third edge", {7'b0, irq_xint[0]}, 8'h01);
    repeat (2) @(negedge clk);
    ack_xint[0] = 1'b1;
    @(negedge clk);
    ack_xint[0] = 1'b0;
    check("R8 ack clears edge flag", {7'b0, irq_xint[0]}, 8'h00);
    repeat (4) @(negedge clk);
    check("R7 steady low no retrigger", {7'b0, irq_xint[0]}, 8'h00);
    xint_n[0] = 1'b1;
    repeat (5) @(negedge clk);
    check("R7 rising edge ignored", {7'b0, irq_xint[0]}, 8'h00);

    // R11 edge collides with ack and a clearing write on int1
    xint_n[1] = 1'b0;
    repeat (2) @(negedge clk);
    ack_xint[1] = 1'b1; sfr_wr = 1'b1; sfr_wdata = 8'h05;
    @(negedge clk);
    idle();
    #1;
    check("R11 edge beats ack and write", sfr_rdata, 8'h0D);

    // R9/R10 level mode on int0
    xint_n[1] = 1'b1;
    wr_reg(8'h00);
    repeat (4) @(negedge clk);
    check("R9 level idle high", {6'b0, irq_xint}, 8'h00);
    xint_n[0] = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 level lag", {7'b0, irq_xint[0]}, 8'h00);
    @(negedge clk);
    check("R9 level follows low pin", {7'b0, irq_xint[0]}, 8'h01);
    wr_reg(8'h00);
    ack_xint[0] = 1'b1;
    @(negedge clk);
    ack_xint[0] = 1'b0;
    #1;
    check("R10 level ignores write and ack", sfr_rdata, 8'h02);
    xint_n[0] = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 level follows high pin", {7'b0, irq_xint[0]}, 8'h00);
    wr_reg(8'h0A);
    #1;
    check("R10 level ignores write of ones", sfr_rdata, 8'h00);

    // R1 reset in mid-run
    wr_reg(8'hF5);
    do_reset();
    #1;
    check("R1 reset mid-run", sfr_rdata, 8'h00);

    finish_run();
  end
endmodule